// File: doc/BRIEF.md
# Teletext Request and Insertion Window Generator

This block drives the request strobe that tells an external teletext source when to deliver serial data, and it captures the bits that come back. It follows horizontal and field timing strobes and counts lines since the last field start. On every line chosen by the line-select mask of the current field, it opens an insertion window a programmed number of pixel clocks after the line strobe. The window length follows a standard-select code: 360, 296 or 288 bit slots, clock run-in included.

Inside the window, a fractional phase accumulator running on the pixel clock marks the teletext bit slots. Each slot marker goes to the source as its timing point. The serial input is sampled a programmable number of pixel clocks after that marker, so the round-trip latency of the source is absorbed. Each sampled bit is presented with a one-cycle valid pulse. The request rises once per selected line and stays high until the next line strobe or until insertion is disabled.

Top module: `vbi_text_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_o`, `in_win_o` and `bit_vld_o` are 0.
- R2: The line index L is the number of `hsync_i` pulses since the last `vsync_i`. `vsync_i` clears the count, and an `hsync_i` in the same cycle counts as 1. A line is selected when FIRST_LINE <= L < FIRST_LINE+SLOTS and bit L-FIRST_LINE is set in the mask that `field_i` picks when sampled with `hsync_i` (0 picks `mask_a_i`, 1 picks `mask_b_i`). An unselected line never raises `req_o`.
- R3: Let `hsync_i` be high in cycle h. On a selected line with `en_i` high, `req_o` is 0 in cycle h+1 and first goes high in cycle h+S+2, where S is `start_i`. It rises at most once per line, stays high until the next `hsync_i`, and is low in the cycle after that strobe.
- R4: The window length N follows `std_i`: code 0 gives 360 bit slots, code 1 gives 296, and codes 2 and 3 give 288. `in_win_o` rises together with `req_o` and stays high up to and including the cycle of the N-th slot marker.
- R5: Count the cycles of an open window as m = 0, 1, 2, ... from the cycle in which `in_win_o` first goes high. Cycle m carries a slot marker when floor((m+1)*BIT_INC/2^16) > floor(m*BIT_INC/2^16), with BIT_INC = 16837 by default.
- R6: For a slot marker in cycle c, `data_i` is sampled at the end of cycle c+D, where D is `delay_i` (0 to 31). The sampled bit appears on `bit_o`, with `bit_vld_o` high for the one cycle c+D+1. Each window delivers exactly N such pulses.
- R7: If `en_i` is low in cycle c, then `req_o` and `in_win_o` are low in cycle c+1 and no further slot markers are issued. Raising `en_i` again later on the same line does not reopen the window. The next selected line works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Insertion enable |
| hsync_i | input | 1 | One-cycle line start strobe |
| vsync_i | input | 1 | One-cycle field start strobe |
| field_i | input | 1 | Field identity (0 first, 1 second), sampled with `hsync_i` |
| mask_a_i | input | SLOTS | Line-select mask for the first field |
| mask_b_i | input | SLOTS | Line-select mask for the second field |
| std_i | input | 2 | Standard select (window length code) |
| start_i | input | PIX_W | Window start offset in pixel clocks after the line strobe |
| delay_i | input | DLY_W | Capture delay in pixel clocks after each slot marker |
| data_i | input | 1 | Serial teletext input from the source |
| req_o | output | 1 | Request strobe to the source |
| in_win_o | output | 1 | Insertion window open |
| bit_o | output | 1 | Captured teletext bit |
| bit_vld_o | output | 1 | One-cycle valid for `bit_o` |

## Verification
The bench predicts every slot marker from the accumulator rule and drives the serial input with a known function of the cycle number. An off-by-one delay tap therefore shows up as wrong bits or a shifted valid pulse. It runs all four standard codes, because a wrong length table would yield 360 bits where 296 or 288 are due. It also checks the first and last mask slots and the first line past the slot range, so an indexing slip lights a neighbouring line or misses the edge. Field swapping is covered by lines set in one mask only. Finally, enable is dropped mid-window and raised again: a design that reopens on re-enable would show a second request rise on the same line.

// File: rtl/vbi_text_gate.sv
module vbi_text_gate #(
  parameter int PIX_W      = 12,
  parameter int LINE_W     = 9,
  parameter int FIRST_LINE = 7,
  parameter int SLOTS      = 16,
  parameter int DLY_W      = 5,
  parameter int ACC_W      = 16,
  parameter int BIT_INC    = 16837,
  parameter int LEN_A      = 360,
  parameter int LEN_B      = 296,
  parameter int LEN_C      = 288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             field_i,
  input  logic [SLOTS-1:0] mask_a_i,
  input  logic [SLOTS-1:0] mask_b_i,
  input  logic [1:0]       std_i,
  input  logic [PIX_W-1:0] start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             data_i,
  output logic             req_o,
  output logic             in_win_o,
  output logic             bit_o,
  output logic             bit_vld_o
);
  localparam int DLY_MAX = (1 << DLY_W) - 1;
  localparam int CNT_W   = $clog2(LEN_A + 1);
  localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [LINE_W:0] LO = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W:0] HI = LINE_W'(FIRST_LINE + SLOTS);
  localparam logic [ACC_W-1:0] INC = ACC_W'(BIT_INC);

  logic [LINE_W-1:0] line_cnt, line_nxt;
  logic [PIX_W-1:0]  pos;
  logic              line_on, req_q, win_q, vld_q, bit_q;
  logic [ACC_W-1:0]  acc, acc_sum;
  logic              carry, strobe, open_w, last_bit, tap, sel;
  logic [CNT_W-1:0]  nbits, win_len;
  logic [DLY_MAX-1:0] dly;
  logic [LINE_W:0]   idx_full;
  logic [SLOTS-1:0]  mask;

  assign line_nxt = vsync_i ? LINE_W'(1)
                  : (&line_cnt) ? line_cnt : line_cnt + LINE_W'(1);
  assign idx_full = {1'b0, line_nxt} - LO;
  assign mask     = field_i ? mask_b_i : mask_a_i;
  assign sel      = ({1'b0, line_nxt} >= LO) && ({1'b0, line_nxt} < HI)
                    && mask[idx_full[SLOT_W-1:0]];

  always_comb begin
    case (std_i)
      2'd0:    win_len = CNT_W'(LEN_A);
      2'd1:    win_len = CNT_W'(LEN_B);
      default: win_len = CNT_W'(LEN_C);
    endcase
  end

  assign {carry, acc_sum} = {1'b0, acc} + {1'b0, INC};
  assign strobe   = win_q && carry;
  assign last_bit = strobe && (nbits == win_len - CNT_W'(1));
  assign open_w   = line_on && en_i && !req_q && !hsync_i && (pos == start_i);
  assign tap      = (delay_i == '0) ? strobe : dly[delay_i - DLY_W'(1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      pos      <= '1;
      line_on  <= 1'b0;
    end else begin
      if (hsync_i) begin
        line_cnt <= line_nxt;
        line_on  <= sel;
        pos      <= '0;
      end else begin
        if (vsync_i) line_cnt <= '0;
        if (pos != '1) pos <= pos + PIX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      win_q <= 1'b0;
      acc   <= '0;
      nbits <= '0;
    end else begin
      if (hsync_i || !en_i) begin
        req_q <= 1'b0;
        win_q <= 1'b0;
      end else if (open_w) begin
        req_q <= 1'b1;
        win_q <= 1'b1;
      end else if (last_bit) begin
        win_q <= 1'b0;
      end
      if (open_w) begin
        acc   <= '0;
        nbits <= '0;
      end else if (win_q) begin
        acc <= acc_sum;
        if (strobe) nbits <= nbits + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly   <= '0;
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      dly   <= {dly[DLY_MAX-2:0], strobe};
      vld_q <= tap;
      if (tap) bit_q <= data_i;
    end
  end

  assign req_o     = req_q;
  assign in_win_o  = win_q;
  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;
endmodule

// File: rtl/vbi_text_gate_chk.sv
module vbi_text_gate_chk #(
  parameter int CNT_W = 9,
  parameter int LEN_A = 360,
  parameter int LEN_B = 296,
  parameter int LEN_C = 288
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             hsync_i,
  input logic [1:0]       std_i,
  input logic             req_o,
  input logic             in_win_o,
  input logic             line_on,
  input logic [CNT_W-1:0] nbits
);
  logic [1:0] rises;
  int unsigned lim;
  assign lim = (std_i == 2'd0) ? LEN_A : (std_i == 2'd1) ? LEN_B : LEN_C;

  always_ff @(posedge clk) begin
    if (!rst_n || hsync_i) rises <= '0;
    else if (req_o && rises == 2'd0) rises <= 2'd1;
    else if (!req_o && rises == 2'd1) rises <= 2'd2;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> !req_o && !in_win_o);
  assert_sel_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> line_on);
  assert_one_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !hsync_i) |-> rises != 2'd2);
  assert_win_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_win_o |-> req_o);
  assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_win_o |-> int'(nbits) < lim);
  assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !req_o && !in_win_o);
endmodule

bind vbi_text_gate vbi_text_gate_chk #(
  .CNT_W(CNT_W), .LEN_A(LEN_A), .LEN_B(LEN_B), .LEN_C(LEN_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .hsync_i(hsync_i), .std_i(std_i),
  .req_o(req_o), .in_win_o(in_win_o), .line_on(line_on), .nbits(nbits)
);

// File: tb/sim_vbi_text_gate.sv
`timescale 1ns/1ps
module sim_vbi_text_gate;
  localparam int INC = 16837;
  logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0;
  logic field_i = 1'b0, data_i = 1'b0;
  logic [15:0] mask_a_i = '0, mask_b_i = '0;
  logic [1:0] std_i = '0;
  logic [11:0] start_i = 12'd10;
  logic [4:0] delay_i = '0;
  logic req_o, in_win_o, bit_o, bit_vld_o;
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vbi_text_gate u0 (.*);

  int r_rise_cnt, r_rise_i, r_win_cnt, r_nvld, r_verr, e_win;
  logic r_req_i1, r_req_k, r_win_k;
  int exp_c[512];
  logic exp_b[512];

  function automatic logic pat(input int c);
    return c[0] ^ c[2] ^ c[5];
  endfunction

  function automatic int len_of(input logic [1:0] s);
    return (s == 2'd0) ? 360 : (s == 2'd1) ? 296 : 288;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic new_field(input logic f);
    @(negedge clk); vsync_i = 1'b1; field_i = f;
    @(negedge clk); vsync_i = 1'b0;
  endtask

  task automatic drive_line(input int len, input int kill_at, input int rest_at);
    int h, w0, ngen, n, d;
    logic prev;
    n = len_of(std_i); d = int'(delay_i); w0 = int'(start_i) + 2;
    r_rise_cnt = 0; r_rise_i = -1; r_win_cnt = 0; r_nvld = 0; r_verr = 0;
    e_win = -1; ngen = 0; prev = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) h = cyc;
      hsync_i = (i == 0);
      data_i = pat(cyc);
      if (i == kill_at) en_i = 1'b0;
      if (i == rest_at) en_i = 1'b1;
      if (i == 1) r_req_i1 = req_o;
      if (i == kill_at + 1) begin r_req_k = req_o; r_win_k = in_win_o; end
      if (req_o && !prev && i > 0) begin r_rise_cnt++; if (r_rise_i < 0) r_rise_i = i; end
      prev = req_o;
      if (in_win_o) r_win_cnt++;
      if (i >= w0 && ngen < n) begin
        longint m = longint'(i - w0);
        if ((((m + 1) * INC) >> 16) != ((m * INC) >> 16)) begin
          exp_c[ngen] = i + d + 1;
          exp_b[ngen] = pat(h + i + d);
          ngen++;
          if (ngen == n) e_win = int'(m) + 1;
        end
      end
      if (bit_vld_o) begin
        if (r_nvld >= n || exp_c[r_nvld] != i || exp_b[r_nvld] != bit_o) r_verr++;
        r_nvld++;
      end
    end
    @(negedge clk); hsync_i = 1'b0;
  endtask

  task automatic short_lines(input int k);
    for (int j = 0; j < k; j++) drive_line(8, -1, -1);
  endtask

  task automatic full_window(input string tag);
    drive_line(1500, -1, -1);
    check(r_rise_i == int'(start_i) + 2, {tag, " R3 rise cycle"}, r_rise_i, int'(start_i) + 2);
    check(r_rise_cnt == 1, {tag, " R3 single rise"}, r_rise_cnt, 1);
    check(r_nvld == len_of(std_i), {tag, " R4 bit count"}, r_nvld, len_of(std_i));
    check(r_win_cnt == e_win, {tag, " R4 R5 window cycles"}, r_win_cnt, e_win);
    check(r_verr == 0, {tag, " R5 R6 bit timing/value"}, r_verr, 0);
  endtask

  task automatic no_window(input string tag);
    drive_line(1500, -1, -1);
    check(r_rise_cnt == 0, {tag, " R2 no request"}, r_rise_cnt, 0);
    check(r_nvld == 0, {tag, " R2 no bits"}, r_nvld, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(!req_o && !in_win_o && !bit_vld_o, "R1 outputs in reset", {req_o, in_win_o, bit_vld_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_o && !in_win_o && !bit_vld_o, "R1 outputs after reset", {req_o, in_win_o, bit_vld_o}, 0);
  endtask

  task automatic t_std_modes;
    en_i = 1'b1; mask_a_i = 16'h0005; mask_b_i = 16'h0006;
    new_field(1'b0); short_lines(6);
    std_i = 2'd0; delay_i = 5'd0; start_i = 12'd10;
    full_window("pal d0");
    std_i = 2'd1; delay_i = 5'd7; start_i = 12'd40;
    no_window("line8 field0");
    check(r_req_i1 == 1'b0, "R3 request low after next hsync", r_req_i1, 0);
    full_window("ntsc d7");
    new_field(1'b1); short_lines(6);
    no_window("line7 field1");
    std_i = 2'd2; delay_i = 5'd31; start_i = 12'd3;
    full_window("code2 d31");
    std_i = 2'd3; delay_i = 5'd3; start_i = 12'd0;
    full_window("code3 d3");
  endtask

  task automatic t_range;
    mask_a_i = 16'hFFFF; std_i = 2'd0; delay_i = 5'd1; start_i = 12'd20;
    new_field(1'b0); short_lines(21);
    full_window("last slot");
    no_window("past range");
  endtask

  task automatic t_disable;
    mask_a_i = 16'hFFFF; std_i = 2'd0; delay_i = 5'd2; start_i = 12'd10;
    new_field(1'b0); short_lines(6);
    drive_line(1500, 200, 300);
    check(!r_req_k && !r_win_k, "R7 request and window drop", {r_req_k, r_win_k}, 0);
    check(r_rise_cnt == 1, "R7 no reopen on re-enable", r_rise_cnt, 1);
    check(r_nvld < 360, "R7 bits stop", r_nvld, 359);
    full_window("after disable R7");
  endtask

  initial begin
    t_reset();
    t_std_modes();
    t_range();
    t_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule